// File: doc/BRIEF.md
# Set-Associative Translation Cache with Page-Range Invalidation

This block holds recently used virtual-to-physical translations for an address translation unit. Storage is split into 64 sets of 8 ways. Each entry maps a 4 KiB, 64 KiB or 1 MiB page. A lookup presents a full virtual address. One cycle later the block returns hit or miss and, on a hit, the full physical address. The page walker installs new translations through a fill port. Software-side control logic removes translations through two paths: a flush that empties the whole structure, and a page-range invalidation that walks successive 4 KiB page numbers.

The set is always chosen by virtual address bits [17:12], including for large pages. A 4 KiB page therefore has exactly one home set. A 64 KiB page can have copies in any of the 16 consecutive sets its address range spans, and a 1 MiB page can have copies in any set. To remove a large page completely, the invalidation sequencer has to visit one page number per set the page covers: 1 step for 4 KiB, 16 for 64 KiB and 64 for 1 MiB. The step count is capped at 64.

The sequencer has two states. In `SQ_IDLE`, an invalidation request clears its first page in the request cycle. If more pages remain, the transition *start walk* moves to `SQ_WALK`, and `busy` is raised. In `SQ_WALK`, one page is cleared per cycle. The transition *walk done* returns to `SQ_IDLE` on the last page.

Top module: `xlat_tlb`

## Requirements
- R1: A lookup request in one cycle produces `lk_done` high in the next cycle, and `lk_done` is low in every other cycle. `lk_hit` is only ever high together with `lk_done`. After reset, `lk_done`, `lk_hit` and `busy` are low and every entry is invalid.
- R2: The set index is virtual page bits [17:12]. A set holds 8 translations. When a fill finds all 8 ways valid, it replaces the least recently used way. Both a lookup hit and a fill count as a use.
- R3: The size code is 0 for 4 KiB, 1 for 64 KiB and 2 for 1 MiB. A lookup hits when the virtual address matches the stored tag above bit 12, 16 or 20 respectively. The physical address returned is the stored page number above that bit, with the lookup address supplying the offset bits below it.
- R4: A fill is placed only in the set selected by its own virtual page bits [17:12]. A 64 KiB entry filled from one address therefore misses for addresses of the same page that select a different set.
- R5: A fill takes the lowest-numbered invalid way of its set in preference to the least recently used way. A fill with size code 3 is ignored.
- R6: An invalidation request with count N clears, in the set selected by each page, every valid entry that covers that page. It does this for N successive 4 KiB page numbers starting at `inv_vpn`. A count of 0 means 1, and counts above 64 are limited to 64. The first page is cleared in the request cycle, and `busy` is high for the N-1 cycles that follow.
- R7: While `busy` is high, a new invalidation request is ignored and a fill is dropped.
- R8: When a fill and the clearing of a page fall in the same cycle, and the fill's page covers the page being cleared, the fill is dropped. A fill that does not cover the cleared page is installed normally.
- R9: `flush_all` invalidates every entry in a single cycle, and a fill presented in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_done | output | 1 | Lookup result valid, one cycle after the request |
| lk_hit | output | 1 | Lookup found a translation |
| lk_pa | output | PA_W | Translated physical address (zero on a miss) |
| fill_req | input | 1 | Install request from the page walker |
| fill_vpn | input | VA_W-12 | Virtual 4 KiB page number of the fill |
| fill_ppn | input | PA_W-12 | Physical 4 KiB page number of the fill |
| fill_size | input | 2 | Page size code: 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB, 3 = reserved |
| inv_req | input | 1 | Page-range invalidation request |
| inv_vpn | input | VA_W-12 | First 4 KiB page number to invalidate |
| inv_pages | input | CNT_W | Number of successive 4 KiB pages to invalidate |
| flush_all | input | 1 | Invalidate all entries |
| busy | output | 1 | Invalidation walk in progress |

## Verification
The sweeps check several corner cases:
- **One entry in every set.** A wrong set index shows up as aliased hits or lost hits.
- **Every 4 KiB slice of a 64 KiB page.** A design that looked in all 16 sets would hit where it must miss.
- **Offsets inside a 1 MiB page.** An offset mask that is too narrow would corrupt the returned address.
- **Page-range invalidation with counts of 0, 16 and 200.** An uncapped counter would run past 64 pages and remove a neighbour that must survive; a wrong `busy` length also shows here.
- **Replacement.** A full set is refilled after a lookup refresh and after a single-way invalidation, so that pure LRU, pure round-robin and ignoring invalid ways each lose a different page.
- **Same-cycle collisions.** Fills are presented in the same cycle as a clear or a flush. A design without priority would leave a stale translation alive.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int PAGE_SHIFT   = 12;
    localparam int SZ64K_SHIFT  = 16;
    localparam int SZ1M_SHIFT   = 20;
    localparam int SZ64K_DROP   = SZ64K_SHIFT - PAGE_SHIFT;
    localparam int SZ1M_DROP    = SZ1M_SHIFT - PAGE_SHIFT;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_RSV = 2'd3
    } pg_size_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_WALK = 1'b1
    } seq_state_e;

endpackage

// File: rtl/tlb_page_cmp.sv
module tlb_page_cmp
    import tlb_pkg::*;
#(
    parameter int PN_W = 20
) (
    input  logic            valid,
    input  pg_size_e        size,
    input  logic [PN_W-1:0] tag,
    input  logic [PN_W-1:0] page,
    output logic            match
);

    always_comb begin
        match = 1'b0;
        if (valid) begin
            unique case (size)
                PG_4K:   match = (tag == page);
                PG_64K:  match = (tag[PN_W-1:SZ64K_DROP] == page[PN_W-1:SZ64K_DROP]);
                PG_1M:   match = (tag[PN_W-1:SZ1M_DROP] == page[PN_W-1:SZ1M_DROP]);
                default: match = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int SETS = 64,
    parameter int WAYS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hit_en,
    input  logic [$clog2(SETS)-1:0]  hit_set,
    input  logic [$clog2(WAYS)-1:0]  hit_way,
    input  logic                     fill_en,
    input  logic [$clog2(SETS)-1:0]  fill_set,
    input  logic [WAYS-1:0]          fill_set_valid,
    output logic [$clog2(WAYS)-1:0]  victim
);

    localparam int IDX_W = $clog2(SETS);
    localparam int AGE_W = $clog2(WAYS);

    typedef logic [WAYS-1:0][AGE_W-1:0] row_t;

    row_t ages [SETS];
    row_t hit_row_nx;
    row_t fill_row_base;
    row_t fill_row_nx;
    logic same_set;

    function automatic row_t touch(input row_t cur, input logic [AGE_W-1:0] way);
        row_t r;
        r = cur;
        for (int i = 0; i < WAYS; i++) begin
            if (cur[i] < cur[way]) r[i] = cur[i] + AGE_W'(1);
        end
        r[way] = '0;
        return r;
    endfunction

    always_comb begin
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (ages[fill_set][w] == AGE_W'(WAYS - 1)) victim = AGE_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!fill_set_valid[w]) victim = AGE_W'(w);
        end
    end

    assign same_set      = hit_en && (hit_set == fill_set);
    assign hit_row_nx    = touch(ages[hit_set], hit_way);
    assign fill_row_base = same_set ? hit_row_nx : ages[fill_set];
    assign fill_row_nx   = touch(fill_row_base, victim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    ages[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            if (hit_en && !(fill_en && same_set)) ages[hit_set] <= hit_row_nx;
            if (fill_en) ages[fill_set] <= fill_row_nx;
        end
    end

    logic unused_idx;
    assign unused_idx = ^{IDX_W{1'b0}};

endmodule

// File: rtl/tlb_inv_seq.sv
module tlb_inv_seq
    import tlb_pkg::*;
#(
    parameter int PN_W    = 20,
    parameter int CNT_W   = 8,
    parameter int INV_MAX = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_req,
    input  logic [PN_W-1:0]  inv_vpn,
    input  logic [CNT_W-1:0] inv_pages,
    output logic             clr_en,
    output logic [PN_W-1:0]  clr_page,
    output logic             busy
);

    localparam int REM_W = $clog2(INV_MAX + 1);

    seq_state_e       state, state_nx;
    logic [PN_W-1:0]  cur_page, cur_page_nx;
    logic [REM_W-1:0] rem, rem_nx;
    logic [REM_W-1:0] eff;

    always_comb begin
        if (inv_pages == '0)                    eff = REM_W'(1);
        else if (32'(inv_pages) > INV_MAX)      eff = REM_W'(INV_MAX);
        else                                    eff = REM_W'(inv_pages);
    end

    always_comb begin
        state_nx    = state;
        cur_page_nx = cur_page;
        rem_nx      = rem;
        unique case (state)
            SQ_IDLE: begin
                if (inv_req && eff > REM_W'(1)) begin
                    state_nx    = SQ_WALK;
                    cur_page_nx = inv_vpn + PN_W'(1);
                    rem_nx      = eff - REM_W'(1);
                end
            end
            SQ_WALK: begin
                cur_page_nx = cur_page + PN_W'(1);
                rem_nx      = rem - REM_W'(1);
                if (rem == REM_W'(1)) state_nx = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            cur_page <= '0;
            rem      <= '0;
        end else begin
            state    <= state_nx;
            cur_page <= cur_page_nx;
            rem      <= rem_nx;
        end
    end

    always_comb begin
        unique case (state)
            SQ_IDLE: begin
                clr_en   = inv_req;
                clr_page = inv_vpn;
                busy     = 1'b0;
            end
            SQ_WALK: begin
                clr_en   = 1'b1;
                clr_page = cur_page;
                busy     = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int SETS    = 64,
    parameter int WAYS    = 8,
    parameter int INV_MAX = 64,
    parameter int CNT_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_req,
    input  logic [VA_W-1:0]            lk_va,
    output logic                       lk_done,
    output logic                       lk_hit,
    output logic [PA_W-1:0]            lk_pa,
    input  logic                       fill_req,
    input  logic [VA_W-PAGE_SHIFT-1:0] fill_vpn,
    input  logic [PA_W-PAGE_SHIFT-1:0] fill_ppn,
    input  logic [1:0]                 fill_size,
    input  logic                       inv_req,
    input  logic [VA_W-PAGE_SHIFT-1:0] inv_vpn,
    input  logic [CNT_W-1:0]           inv_pages,
    input  logic                       flush_all,
    output logic                       busy
);

    localparam int PN_W  = VA_W - PAGE_SHIFT;
    localparam int PPN_W = PA_W - PAGE_SHIFT;
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam logic [PA_W-1:0] MSK_4K  = PA_W'((64'd1 << PAGE_SHIFT) - 1);
    localparam logic [PA_W-1:0] MSK_64K = PA_W'((64'd1 << SZ64K_SHIFT) - 1);
    localparam logic [PA_W-1:0] MSK_1M  = PA_W'((64'd1 << SZ1M_SHIFT) - 1);

    // entry storage: valid bits carry a reset, payload does not
    logic [WAYS-1:0]                 vld  [SETS];
    logic [WAYS-1:0][1:0]            esz  [SETS];
    logic [WAYS-1:0][PN_W-1:0]       etag [SETS];
    logic [WAYS-1:0][PPN_W-1:0]      eppn [SETS];

    logic [PN_W-1:0]  lk_page;
    logic [IDX_W-1:0] lk_set, fill_set, clr_set;
    logic             clr_en;
    logic [PN_W-1:0]  clr_page;
    logic [WAYS-1:0]  lk_match, clr_match;
    logic             lk_any;
    logic [WAY_W-1:0] lk_way;
    logic [PA_W-1:0]  pa_sel;
    logic [PA_W-1:0]  lk_off;
    logic             fill_covers;
    logic             fill_take;
    logic [WAY_W-1:0] victim;

    assign lk_page  = lk_va[VA_W-1:PAGE_SHIFT];
    assign lk_set   = lk_page[IDX_W-1:0];
    assign fill_set = fill_vpn[IDX_W-1:0];
    assign clr_set  = clr_page[IDX_W-1:0];
    assign lk_off   = PA_W'(lk_va[SZ1M_SHIFT-1:0]);

    tlb_inv_seq #(
        .PN_W    (PN_W),
        .CNT_W   (CNT_W),
        .INV_MAX (INV_MAX)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_req   (inv_req),
        .inv_vpn   (inv_vpn),
        .inv_pages (inv_pages),
        .clr_en    (clr_en),
        .clr_page  (clr_page),
        .busy      (busy)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_page_cmp #(.PN_W(PN_W)) u_lk_cmp (
            .valid (vld[lk_set][w]),
            .size  (pg_size_e'(esz[lk_set][w])),
            .tag   (etag[lk_set][w]),
            .page  (lk_page),
            .match (lk_match[w])
        );
        tlb_page_cmp #(.PN_W(PN_W)) u_clr_cmp (
            .valid (vld[clr_set][w]),
            .size  (pg_size_e'(esz[clr_set][w])),
            .tag   (etag[clr_set][w]),
            .page  (clr_page),
            .match (clr_match[w])
        );
    end

    // does the incoming fill's own page contain the page being cleared?
    tlb_page_cmp #(.PN_W(PN_W)) u_fill_cov (
        .valid (1'b1),
        .size  (pg_size_e'(fill_size)),
        .tag   (fill_vpn),
        .page  (clr_page),
        .match (fill_covers)
    );

    always_comb begin
        lk_any = |lk_match;
        lk_way = '0;
        pa_sel = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_match[w]) lk_way = WAY_W'(w);
        end
        for (int w = 0; w < WAYS; w++) begin
            if (lk_match[w]) begin
                unique case (pg_size_e'(esz[lk_set][w]))
                    PG_64K:  pa_sel = pa_sel | (({eppn[lk_set][w], {PAGE_SHIFT{1'b0}}} & ~MSK_64K) | (lk_off & MSK_64K));
                    PG_1M:   pa_sel = pa_sel | (({eppn[lk_set][w], {PAGE_SHIFT{1'b0}}} & ~MSK_1M) | (lk_off & MSK_1M));
                    default: pa_sel = pa_sel | (({eppn[lk_set][w], {PAGE_SHIFT{1'b0}}} & ~MSK_4K) | (lk_off & MSK_4K));
                endcase
            end
        end
    end

    assign fill_take = fill_req && !busy && !flush_all &&
                       (pg_size_e'(fill_size) != PG_RSV) &&
                       !(clr_en && fill_covers);

    tlb_lru #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) u_lru (
        .clk            (clk),
        .rst_n          (rst_n),
        .hit_en         (lk_req && lk_any),
        .hit_set        (lk_set),
        .hit_way        (lk_way),
        .fill_en        (fill_take),
        .fill_set       (fill_set),
        .fill_set_valid (vld[fill_set]),
        .victim         (victim)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || flush_all) begin
            for (int s = 0; s < SETS; s++) vld[s] <= '0;
        end else begin
            if (clr_en) vld[clr_set] <= vld[clr_set] & ~clr_match;
            if (fill_take) vld[fill_set][victim] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_take) begin
            esz[fill_set][victim]  <= fill_size;
            etag[fill_set][victim] <= fill_vpn;
            eppn[fill_set][victim] <= fill_ppn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_done <= 1'b0;
            lk_hit  <= 1'b0;
            lk_pa   <= '0;
        end else begin
            lk_done <= lk_req;
            lk_hit  <= lk_req && lk_any;
            lk_pa   <= (lk_req && lk_any) ? pa_sel : '0;
        end
    end

endmodule

// File: rtl/tlb_checks.sv
module tlb_checks #(
    parameter int CNT_W   = 8,
    parameter int INV_MAX = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic             lk_done,
    input logic             lk_hit,
    input logic             inv_req,
    input logic [CNT_W-1:0] inv_pages,
    input logic             flush_all,
    input logic             busy
);

    localparam int RUN_W = $clog2(INV_MAX + 1) + 1;

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + RUN_W'(1);
        else           busy_run <= '0;
    end

    a_r1_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_done);

    a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_done);

    a_r1_hit_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_done);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |-> ##2 !lk_hit);

    a_r6_walk_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run < RUN_W'(INV_MAX));

    a_r6_walk_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !busy && inv_pages > CNT_W'(1)) |=> busy);

    a_r6_single_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !busy && inv_pages <= CNT_W'(1)) |=> !busy);

endmodule

bind xlat_tlb tlb_checks #(
    .CNT_W   (CNT_W),
    .INV_MAX (INV_MAX)
) u_tlb_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .lk_done   (lk_done),
    .lk_hit    (lk_hit),
    .inv_req   (inv_req),
    .inv_pages (inv_pages),
    .flush_all (flush_all),
    .busy      (busy)
);

// File: tb/test_xlat_tlb.sv
`timescale 1ns/1ps
module test_xlat_tlb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req;
    logic [31:0] lk_va;
    logic        lk_done;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic        fill_req;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic [1:0]  fill_size;
    logic        inv_req;
    logic [19:0] inv_vpn;
    logic [7:0]  inv_pages;
    logic        flush_all;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    xlat_tlb i_xlat_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_req    (lk_req),
        .lk_va     (lk_va),
        .lk_done   (lk_done),
        .lk_hit    (lk_hit),
        .lk_pa     (lk_pa),
        .fill_req  (fill_req),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn),
        .fill_size (fill_size),
        .inv_req   (inv_req),
        .inv_vpn   (inv_vpn),
        .inv_pages (inv_pages),
        .flush_all (flush_all),
        .busy      (busy)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual %0d expected <150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] va, input bit exp_hit, input logic [31:0] exp_pa, input string req);
        lk_req = 1'b1;
        lk_va  = va;
        tick();
        lk_req = 1'b0;
        chk(lk_done === 1'b1 && lk_hit === exp_hit, req, {30'b0, lk_done, lk_hit}, {30'b0, 1'b1, exp_hit});
        if (exp_hit) chk(lk_pa === exp_pa, req, lk_pa, exp_pa);
    endtask

    task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
        fill_req  = 1'b1;
        fill_vpn  = va[31:12];
        fill_ppn  = pa[31:12];
        fill_size = sz;
        tick();
        fill_req  = 1'b0;
    endtask

    task automatic inv(input logic [31:0] va, input logic [7:0] pages, input int exp_busy, input string req);
        int n;
        inv_req   = 1'b1;
        inv_vpn   = va[31:12];
        inv_pages = pages;
        tick();
        inv_req   = 1'b0;
        n = 0;
        while (busy && n < 300) begin
            n++;
            tick();
        end
        chk(n == exp_busy, req, n, exp_busy);
    endtask

    task automatic flush();
        flush_all = 1'b1;
        tick();
        flush_all = 1'b0;
    endtask

    function automatic logic [31:0] set5(input int tag);
        return (32'(tag) << 18) | 32'h0000_5000;
    endfunction

    initial begin
        rst_n = 1'b0; lk_req = 1'b0; lk_va = '0; fill_req = 1'b0; fill_vpn = '0;
        fill_ppn = '0; fill_size = '0; inv_req = 1'b0; inv_vpn = '0; inv_pages = '0;
        flush_all = 1'b0;
        repeat (3) tick();
        // R1 reset state
        chk(lk_done === 1'b0 && lk_hit === 1'b0 && busy === 1'b0, "R1 reset outputs",
            {29'b0, lk_done, lk_hit, busy}, 32'h0);
        rst_n = 1'b1;
        tick();
        chk(lk_done === 1'b0, "R1 idle done", {31'b0, lk_done}, 32'h0);
        look(32'h0000_0000, 1'b0, 32'h0, "R1 empty after reset");

        // R2 one 4K entry in every set, distinct tags
        for (int s = 0; s < 64; s++)
            fill((32'(s + 1) << 18) | (32'(s) << 12), 32'h3000_0000 | (32'(s) << 12), 2'd0);
        for (int s = 0; s < 64; s++)
            look((32'(s + 1) << 18) | (32'(s) << 12) | 32'h0000_0ABC, 1'b1,
                 32'h3000_0000 | (32'(s) << 12) | 32'h0000_0ABC, "R2 per-set 4K hit");
        look((32'd70 << 18) | (32'd3 << 12), 1'b0, 32'h0, "R2 other tag misses");

        // R2 LRU replacement in set 5
        flush();
        for (int t = 1; t <= 8; t++) fill(set5(t), 32'h4000_0000 | (32'(t) << 12), 2'd0);
        look(set5(1), 1'b1, 32'h4000_1000, "R2 refresh tag1");
        fill(set5(9), 32'h4000_9000, 2'd0);
        look(set5(2), 1'b0, 32'h0, "R2 LRU way evicted");
        for (int t = 1; t <= 9; t++)
            if (t != 2) look(set5(t), 1'b1, 32'h4000_0000 | (32'(t) << 12), "R2 survivors hit");

        // R5 invalid way preferred over LRU
        flush();
        for (int t = 1; t <= 8; t++) fill(set5(t), 32'h5000_0000 | (32'(t) << 12), 2'd0);
        inv(set5(5), 8'd1, 0, "R6 single inv busy");
        fill(set5(10), 32'h5000_A000, 2'd0);
        look(set5(5), 1'b0, 32'h0, "R6 single page cleared");
        look(set5(1), 1'b1, 32'h5000_1000, "R5 LRU kept when a way is free");
        look(set5(10), 1'b1, 32'h5000_A000, "R5 new fill present");
        fill(32'h0E00_0000, 32'h6000_0000, 2'd3);
        look(32'h0E00_0000, 1'b0, 32'h0, "R5 reserved size ignored");

        // R3 1 MiB entry, offsets inside the page within set 5
        flush();
        fill(32'h0A00_5000, 32'h0C30_0000, 2'd2);
        for (int k = 0; k < 4; k++)
            for (int o = 0; o < 4096; o += 1365)
                look(32'h0A00_5000 | (32'(k) << 18) | 32'(o), 1'b1,
                     32'h0C30_5000 | (32'(k) << 18) | 32'(o), "R3 1M offset");
        look(32'h0B00_5000, 1'b0, 32'h0, "R3 other 1M page misses");

        // R3/R4 64 KiB entry filled from slice 7 only
        flush();
        fill(32'h0DE0_7000, 32'h0F12_0000, 2'd1);
        for (int j = 0; j < 16; j++)
            look(32'h0DE0_0044 | (32'(j) << 12), j == 7, 32'h0F12_0044 | (32'(j) << 12),
                 (j == 7) ? "R3 64K hit" : "R4 other slice misses");

        // R6 invalidate a 64 KiB page spread over 16 sets
        flush();
        for (int k = 0; k < 16; k++) fill(32'h0123_0000 + (32'(k) << 12), 32'h0456_0000, 2'd1);
        fill(32'h0223_5000, 32'h0777_7000, 2'd0);
        for (int k = 0; k < 16; k++)
            look(32'h0123_0ABC + (32'(k) << 12), 1'b1, 32'h0456_0ABC + (32'(k) << 12), "R3 64K copies");
        inv(32'h0123_0000, 8'd16, 15, "R6 16-page busy length");
        for (int k = 0; k < 16; k++)
            look(32'h0123_0000 + (32'(k) << 12), 1'b0, 32'h0, "R6 64K copies gone");
        look(32'h0223_5010, 1'b1, 32'h0777_7010, "R6 neighbour survives");

        // R6 count cap at 64
        flush();
        for (int k = 0; k <= 64; k++) fill(32'h0400_0000 + (32'(k) << 12), 32'h8000_0000 + (32'(k) << 12), 2'd0);
        inv(32'h0400_0000, 8'd200, 63, "R6 capped busy length");
        for (int k = 0; k < 64; k++)
            look(32'h0400_0000 + (32'(k) << 12), 1'b0, 32'h0, "R6 capped range cleared");
        look(32'h0404_0000, 1'b1, 32'h8004_0000, "R6 page past cap survives");

        // R6 count zero means one page
        flush();
        fill(32'h0900_0000, 32'h0100_0000, 2'd0);
        fill(32'h0900_1000, 32'h0100_1000, 2'd0);
        inv(32'h0900_0000, 8'd0, 0, "R6 zero count busy");
        look(32'h0900_0000, 1'b0, 32'h0, "R6 zero count clears one");
        look(32'h0900_1000, 1'b1, 32'h0100_1000, "R6 zero count spares next");

        // R7 requests while busy are ignored
        flush();
        fill(32'h0030_0000, 32'h2220_0000, 2'd0);
        inv_req = 1'b1; inv_vpn = 20'h00100; inv_pages = 8'd10;
        tick();
        chk(busy === 1'b1, "R6 walk busy", {31'b0, busy}, 32'h1);
        inv_vpn = 20'h00300; inv_pages = 8'd1;
        fill_req = 1'b1; fill_vpn = 20'h00503; fill_ppn = 20'h12345; fill_size = 2'd0;
        tick();
        inv_req = 1'b0; fill_req = 1'b0;
        while (busy) tick();
        look(32'h0030_0010, 1'b1, 32'h2220_0010, "R7 inv during walk ignored");
        look(32'h0050_3000, 1'b0, 32'h0, "R7 fill during walk dropped");

        // R8 same-cycle fill and clear
        flush();
        fill_req = 1'b1; fill_vpn = 20'h07000; fill_ppn = 20'h0D000; fill_size = 2'd2;
        inv_req = 1'b1; inv_vpn = 20'h07083; inv_pages = 8'd1;
        tick();
        fill_req = 1'b0; inv_req = 1'b0;
        look(32'h0700_0000, 1'b0, 32'h0, "R8 covering fill dropped");
        fill_req = 1'b1; fill_vpn = 20'h08001; fill_ppn = 20'h0E001; fill_size = 2'd0;
        inv_req = 1'b1; inv_vpn = 20'h08002; inv_pages = 8'd1;
        tick();
        fill_req = 1'b0; inv_req = 1'b0;
        look(32'h0800_1020, 1'b1, 32'h0E00_1020, "R8 unrelated fill kept");

        // R9 flush with a simultaneous fill
        fill(32'h0600_1000, 32'h0A00_1000, 2'd0);
        fill(32'h0620_0000, 32'h0B00_0000, 2'd2);
        flush_all = 1'b1;
        fill_req = 1'b1; fill_vpn = 20'h06402; fill_ppn = 20'h0C002; fill_size = 2'd0;
        tick();
        flush_all = 1'b0; fill_req = 1'b0;
        look(32'h0600_1000, 1'b0, 32'h0, "R9 4K flushed");
        look(32'h0620_0000, 1'b0, 32'h0, "R9 1M flushed");
        look(32'h0640_2000, 1'b0, 32'h0, "R9 same-cycle fill dropped");
        look(32'h0800_1000, 1'b0, 32'h0, "R9 earlier entry flushed");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule